// File: doc/BRIEF.md
# Program Flow Time-Slot Monitor

This block supervises software sequencing from a clock that is independent of the processor clock. Each significant routine writes its own fixed token value to a token register. It never increments the register. The processor also pulses an event input on every interrupt it services. A slot timer in the monitor clock domain divides time into fixed slots. At the end of each slot, the monitor checks two things. First, the last token accepted in the slot must equal a programmed expected token. Second, the number of interrupt events must lie inside a programmed inclusive window. After the check, the monitor clears its captured token and its event count.

Any failed check raises a sticky fault output. A three-bit cause vector records which checks have failed. Software programs the expected token and the window bounds, then sets an arm bit. That locks the configuration. Checking starts with the first full slot after the monitor has seen the arm bit. The fault output is meant to feed a separate watchdog or safe-state path, and this block does not replace that path. Token writes and event pulses cross into the monitor domain through two-flop synchronizers. Token data is carried by a toggle request/acknowledge handshake.

Top module: `flow_slot_monitor`

## Requirements
- R1: After reset, `fault` is 0 and `fault_cause` is 3'b000.
- R2: A slot ends every SLOT_CYCLES `mon_clk` cycles after reset. The monitor arms at the first slot end at which the arm bit (address 4, data bit 0 = 1) has been seen. Only slot ends after that one evaluate the checks, so nothing that happens before arming raises a fault.
- R3: At an evaluated slot end, if the last token accepted during the slot (written to address 0) differs from the expected token (address 1), cause bit 0 is set. A slot with no accepted token write compares the value zero.
- R4: At an evaluated slot end, if the interrupt event count is below the minimum (address 2), cause bit 1 is set. A count equal to the minimum passes.
- R5: At an evaluated slot end, if the event count is above the maximum (address 3), cause bit 2 is set. A count equal to the maximum passes.
- R6: Cause bits only accumulate and clear only on reset. `fault` is the OR of the cause bits.
- R7: Once the arm bit is set, writes to addresses 1, 2 and 3 have no effect.
- R8: A token write made while the previous token transfer is still unacknowledged is discarded.
- R9: The captured token and the event count return to zero at every slot end, so each slot is judged on its own writes and events.
- R10: When several tokens are accepted within one slot, the last one is the one compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Synchronous active-low reset, processor side |
| mon_clk | input | 1 | Independent monitor time base |
| mon_rst_n | input | 1 | Synchronous active-low reset, monitor side |
| wr_en | input | 1 | Register write strobe (cpu_clk) |
| wr_addr | input | 3 | 0 token, 1 expected token, 2 minimum count, 3 maximum count, 4 arm |
| wr_data | input | DATA_W | Write data |
| irq_evt | input | 1 | One-cycle pulse per serviced interrupt (cpu_clk), at least two cycles apart |
| fault | output | 1 | Sticky fault (mon_clk) |
| fault_cause | output | 3 | bit0 token mismatch, bit1 too few events, bit2 too many events |

## Verification
The slot checks are exercised with a range of patterns. Correct slots place the event count exactly on the minimum and exactly on the maximum, which shows the window is inclusive. A wrong token, a missing token, a count one below the window and a count one above it each set only their own cause bit. A good slot followed by a slot with no write shows that the capture is cleared at each slot end. Two writes in one slot, first in correct-then-wrong order and then in wrong-then-correct order, show that the last write is the one compared. A back-to-back pair of writes shows that a write made while a transfer is pending is dropped. Configuration writes made after arming, followed by slots that use the old and the new expected token, show that the configuration is locked.

// File: rtl/pfm_pkg.sv
// Package: shared register addresses and cause-bit positions for the
// program flow time-slot monitor.
package pfm_pkg;
    typedef enum logic [2:0] {
        ADDR_TOKEN = 3'd0,
        ADDR_EXP   = 3'd1,
        ADDR_MIN   = 3'd2,
        ADDR_MAX   = 3'd3,
        ADDR_ARM   = 3'd4
    } pfm_addr_e;

    localparam int CAUSE_W    = 3;
    localparam int CAUSE_TOK  = 0;
    localparam int CAUSE_LOW  = 1;
    localparam int CAUSE_HIGH = 2;
endpackage

// File: rtl/pfm_sync.sv
// Module: multi-stage level synchronizer for a vector of independent bits.
// Assumes each bit is a slowly changing level or toggle (no bus coherence).
module pfm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first capture flop of the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_rest
                // further resolution flops
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pfm_cpu_port.sv
// Module: processor-side register port. Holds the configuration (locked once
// armed), launches token transfers as toggle requests, and turns event
// pulses into a toggle. Assumes ack_s is the synchronized acknowledge toggle.
module pfm_cpu_port
    import pfm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TOK_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_evt,
    input  logic              ack_s,
    output logic [TOK_W-1:0]  tok_hold,
    output logic              req_tgl,
    output logic              irq_tgl,
    output logic [TOK_W-1:0]  exp_tok,
    output logic [CNT_W-1:0]  min_cnt,
    output logic [CNT_W-1:0]  max_cnt,
    output logic              arm_req
);
    logic pending;
    assign pending = (req_tgl != ack_s);

    // configuration registers, frozen once the arm bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_tok <= '0;
            min_cnt <= '0;
            max_cnt <= '0;
            arm_req <= 1'b0;
        end else if (wr_en && !arm_req) begin
            case (pfm_addr_e'(wr_addr))
                ADDR_EXP: exp_tok <= wr_data[TOK_W-1:0];
                ADDR_MIN: min_cnt <= wr_data[CNT_W-1:0];
                ADDR_MAX: max_cnt <= wr_data[CNT_W-1:0];
                ADDR_ARM: arm_req <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // token launch: accept only when no transfer is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_hold <= '0;
            req_tgl  <= 1'b0;
        end else if (wr_en && (pfm_addr_e'(wr_addr) == ADDR_TOKEN) && !pending) begin
            tok_hold <= wr_data[TOK_W-1:0];
            req_tgl  <= ~req_tgl;
        end
    end

    // interrupt event pulses become level toggles for the crossing
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_tgl <= 1'b0;
        else if (irq_evt) irq_tgl <= ~irq_tgl;
    end
endmodule

// File: rtl/pfm_slot_core.sv
// Module: monitor-domain slot engine. Runs the slot timer, captures tokens
// and counts events, evaluates both at each slot end once armed, and holds
// the sticky cause bits. Assumes tok_hold and the limits are quasi-static
// whenever their qualifying toggles are seen.
module pfm_slot_core
    import pfm_pkg::*;
#(
    parameter int TOK_W       = 8,
    parameter int CNT_W       = 8,
    parameter int SLOT_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_s,
    input  logic               irq_s,
    input  logic               arm_s,
    input  logic [TOK_W-1:0]   tok_hold,
    input  logic [TOK_W-1:0]   exp_tok,
    input  logic [CNT_W-1:0]   min_cnt,
    input  logic [CNT_W-1:0]   max_cnt,
    output logic               ack_tgl,
    output logic [CAUSE_W-1:0] cause,
    output logic               slot_end,
    output logic               armed,
    output logic [CNT_W-1:0]   irq_cnt
);
    localparam int          SLOT_W  = $clog2(SLOT_CYCLES + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
    localparam logic [CNT_W-1:0]  CNT_TOP   = {CNT_W{1'b1}};

    logic [SLOT_W-1:0] timer;
    logic [TOK_W-1:0]  cap_tok;
    logic              irq_seen;
    logic              tok_evt;
    logic              irq_inc;
    logic [CAUSE_W-1:0] verdict;

    assign tok_evt  = (req_s != ack_tgl);
    assign irq_inc  = (irq_s != irq_seen);
    assign slot_end = (timer == SLOT_LAST);

    // slot timer on the independent time base
    always_ff @(posedge clk) begin
        if (!rst_n)        timer <= '0;
        else if (slot_end) timer <= '0;
        else               timer <= timer + 1'b1;
    end

    // acknowledge and event edge trackers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_tgl  <= 1'b0;
            irq_seen <= 1'b0;
        end else begin
            ack_tgl  <= req_s;
            irq_seen <= irq_s;
        end
    end

    // token capture, cleared at slot end unless a new token lands there
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_tok <= '0;
        else if (tok_evt)  cap_tok <= tok_hold;
        else if (slot_end) cap_tok <= '0;
    end

    // saturating event counter, restarted at slot end
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq_cnt <= '0;
        else if (slot_end)                   irq_cnt <= irq_inc ? CNT_W'(1) : '0;
        else if (irq_inc && irq_cnt != CNT_TOP) irq_cnt <= irq_cnt + CNT_W'(1);
    end

    // slot verdict from the capture and the window
    always_comb begin
        verdict             = '0;
        verdict[CAUSE_TOK]  = (cap_tok != exp_tok);
        verdict[CAUSE_LOW]  = (irq_cnt < min_cnt);
        verdict[CAUSE_HIGH] = (irq_cnt > max_cnt);
    end

    // arming and sticky cause accumulation at slot ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cause <= '0;
        end else if (slot_end) begin
            if (armed) cause <= cause | verdict;
            if (arm_s) armed <= 1'b1;
        end
    end
endmodule

// File: rtl/flow_slot_monitor.sv
// Module: top of the program flow time-slot monitor. Joins the processor
// port, the clock crossings and the slot engine. Assumes cpu_clk and
// mon_clk are unrelated and each reset is held for a few cycles of its clock.
module flow_slot_monitor
    import pfm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TOK_W       = 8,
    parameter int CNT_W       = 8,
    parameter int SLOT_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               cpu_clk,
    input  logic               cpu_rst_n,
    input  logic               mon_clk,
    input  logic               mon_rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               irq_evt,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause
);
    logic [TOK_W-1:0] tok_hold;
    logic [TOK_W-1:0] exp_tok;
    logic [CNT_W-1:0] min_cnt;
    logic [CNT_W-1:0] max_cnt;
    logic [CNT_W-1:0] irq_cnt;
    logic             req_tgl;
    logic             irq_tgl;
    logic             arm_req;
    logic             ack_tgl;
    logic             ack_s;
    logic [2:0]       to_mon_s;
    logic             slot_end;
    logic             armed;

    pfm_cpu_port #(.DATA_W(DATA_W), .TOK_W(TOK_W), .CNT_W(CNT_W)) u_port (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_evt(irq_evt), .ack_s(ack_s),
        .tok_hold(tok_hold), .req_tgl(req_tgl), .irq_tgl(irq_tgl),
        .exp_tok(exp_tok), .min_cnt(min_cnt), .max_cnt(max_cnt),
        .arm_req(arm_req)
    );

    pfm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_to_mon (
        .clk(mon_clk), .rst_n(mon_rst_n),
        .d({arm_req, irq_tgl, req_tgl}), .q(to_mon_s)
    );

    pfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_to_cpu (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_s)
    );

    pfm_slot_core #(.TOK_W(TOK_W), .CNT_W(CNT_W), .SLOT_CYCLES(SLOT_CYCLES)) u_core (
        .clk(mon_clk), .rst_n(mon_rst_n),
        .req_s(to_mon_s[0]), .irq_s(to_mon_s[1]), .arm_s(to_mon_s[2]),
        .tok_hold(tok_hold), .exp_tok(exp_tok),
        .min_cnt(min_cnt), .max_cnt(max_cnt),
        .ack_tgl(ack_tgl), .cause(fault_cause), .slot_end(slot_end),
        .armed(armed), .irq_cnt(irq_cnt)
    );

    assign fault = |fault_cause;
endmodule

// File: rtl/flow_slot_monitor_chk.sv
// Module: property checker for flow_slot_monitor, bound to the top.
// Assumes the monitor-domain clock and reset.
module flow_slot_monitor_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault,
    input logic [2:0]       cause,
    input logic             slot_end,
    input logic             armed,
    input logic [CNT_W-1:0] irq_cnt
);
    // R6: the fault output never drops without reset
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R6: no cause bit is ever cleared
    a_r6_cause_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & $past(cause)) == $past(cause)));

    // R2: causes change only at a slot end
    a_r2_quiet_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> $stable(cause));

    // R2: nothing is judged before arming
    a_r2_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(cause));

    // R9: the event count restarts at each slot end
    a_r9_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (irq_cnt <= CNT_W'(1)));
endmodule

bind flow_slot_monitor flow_slot_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(mon_clk), .rst_n(mon_rst_n), .fault(fault), .cause(fault_cause),
    .slot_end(slot_end), .armed(armed), .irq_cnt(irq_cnt)
);

// File: tb/flow_slot_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural slot model compared with the outputs on every mon_clk.
module flow_slot_monitor_tb_top;
    localparam int SLOT = 128;

    logic       cpu_clk = 1'b0;
    logic       mon_clk = 1'b0;
    logic       cpu_rst_n = 1'b0;
    logic       mon_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_evt = 1'b0;
    logic       fault;
    logic [2:0] fault_cause;

    always #2.5 mon_clk = ~mon_clk;
    always #3.5 cpu_clk = ~cpu_clk;

    flow_slot_monitor #(.SLOT_CYCLES(SLOT)) dut_i (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .mon_clk(mon_clk),
        .mon_rst_n(mon_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_evt(irq_evt), .fault(fault),
        .fault_cause(fault_cause)
    );

    int    checks = 0;
    int    errors = 0;
    int    k = 0;
    string cur_req = "R1";
    logic [2:0] m_cause = '0;
    bit    m_armed = 0;
    bit    m_done = 0;
    logic [7:0] m_exp = '0;
    int    m_min = 0;
    int    m_max = 0;
    logic [7:0] slot_tok = '0;
    int    slot_irq = 0;

    // reference model: slot ends, arming and sticky causes
    always @(posedge mon_clk) begin
        if (!mon_rst_n) begin
            k = 0; m_cause = '0; m_armed = 0; slot_tok = '0; slot_irq = 0;
        end else begin
            k = k + 1;
            if (k % SLOT == 0) begin
                if (m_armed) begin
                    if (slot_tok != m_exp) m_cause[0] = 1'b1;
                    if (slot_irq < m_min)  m_cause[1] = 1'b1;
                    if (slot_irq > m_max)  m_cause[2] = 1'b1;
                end
                slot_tok = '0;
                slot_irq = 0;
                if (m_done) m_armed = 1;
            end
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge mon_clk) begin
        if (mon_rst_n && k > 0) begin
            checks++;
            if (fault !== (|m_cause) || fault_cause !== m_cause) begin
                errors++;
                $display("FAIL %s: fault=%b cause=%b expected fault=%b cause=%b",
                         cur_req, fault, fault_cause, |m_cause, m_cause);
            end
        end
    end

    task automatic check_cause(input string req, input logic [2:0] exp);
        @(negedge mon_clk);
        checks++;
        if (fault_cause !== exp || fault !== (|exp)) begin
            errors++;
            $display("FAIL %s: cause=%b fault=%b expected cause=%b", req,
                     fault_cause, fault, exp);
        end
    endtask

    task automatic wait_k(input int t);
        while (k < t) @(negedge mon_clk);
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge cpu_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge cpu_clk);
        wr_en = 1'b0;
    endtask

    task automatic tok_write(input logic [7:0] d);
        cpu_write(3'd0, d);
        slot_tok = d;
        repeat (12) @(negedge cpu_clk);
    endtask

    task automatic irq_pulse();
        @(negedge cpu_clk);
        irq_evt = 1'b1;
        slot_irq = slot_irq + 1;
        @(negedge cpu_clk);
        irq_evt = 1'b0;
        repeat (2) @(negedge cpu_clk);
    endtask

    // one slot: optional tokens (negative = none) then n events
    task automatic run_slot(input int t1, input int t2, input int n);
        int j;
        j = k / SLOT;
        wait_k(j * SLOT + 8);
        if (t1 >= 0) tok_write(8'(t1));
        if (t2 >= 0) tok_write(8'(t2));
        for (int i = 0; i < n; i++) irq_pulse();
        wait_k((j + 1) * SLOT + 2);
    endtask

    task automatic do_reset();
        cpu_rst_n = 1'b0; mon_rst_n = 1'b0; m_done = 0;
        repeat (6) @(negedge mon_clk);
        mon_rst_n = 1'b1;
        @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        m_exp = 8'h5A; m_min = 2; m_max = 5;
        cpu_write(3'd1, 8'h5A);
        cpu_write(3'd2, 8'd2);
        cpu_write(3'd3, 8'd5);
        cpu_write(3'd4, 8'd1);
        m_done = 1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        do_reset();
        check_cause("R1", 3'b000);

        // R2 unarmed slot not judged; R4/R5 inclusive window bounds pass
        cur_req = "R2";
        run_slot(-1, -1, 0);
        check_cause("R2", 3'b000);
        cur_req = "R4";
        run_slot(8'h5A, -1, 2);
        check_cause("R4", 3'b000);
        cur_req = "R5";
        run_slot(8'h5A, -1, 5);
        check_cause("R5", 3'b000);

        // R3 wrong token, then R6 stickiness and accumulation
        cur_req = "R3";
        run_slot(8'h33, -1, 3);
        check_cause("R3", 3'b001);
        cur_req = "R6";
        run_slot(8'h5A, -1, 3);
        check_cause("R6", 3'b001);
        run_slot(8'h5A, -1, 0);
        check_cause("R6", 3'b011);
        do_reset();
        check_cause("R6", 3'b000);

        // R4 one below minimum
        cur_req = "R4";
        run_slot(-1, -1, 0);
        run_slot(8'h5A, -1, 1);
        check_cause("R4", 3'b010);

        // R5 one above maximum
        cur_req = "R5";
        do_reset();
        run_slot(-1, -1, 0);
        run_slot(8'h5A, -1, 6);
        check_cause("R5", 3'b100);

        // R9 capture cleared: good slot then a slot without token
        cur_req = "R9";
        do_reset();
        run_slot(-1, -1, 0);
        run_slot(8'h5A, -1, 3);
        check_cause("R9", 3'b000);
        run_slot(-1, -1, 3);
        check_cause("R9", 3'b001);

        // R10 last token in a slot wins
        cur_req = "R10";
        do_reset();
        run_slot(-1, -1, 0);
        run_slot(8'h11, 8'h5A, 3);
        check_cause("R10", 3'b000);
        run_slot(8'h5A, 8'h11, 3);
        check_cause("R10", 3'b001);

        // R8 write during pending transfer dropped
        cur_req = "R8";
        do_reset();
        run_slot(-1, -1, 0);
        wait_k(SLOT + 8);
        cpu_write(3'd0, 8'h5A);
        slot_tok = 8'h5A;
        cpu_write(3'd0, 8'h22);
        repeat (12) @(negedge cpu_clk);
        for (int i = 0; i < 3; i++) irq_pulse();
        wait_k(2 * SLOT + 2);
        check_cause("R8", 3'b000);

        // R7 configuration locked after arming
        cur_req = "R7";
        do_reset();
        cpu_write(3'd1, 8'h77);
        cpu_write(3'd2, 8'd0);
        cpu_write(3'd3, 8'd9);
        run_slot(-1, -1, 0);
        run_slot(8'h5A, -1, 3);
        check_cause("R7", 3'b000);
        run_slot(8'h77, -1, 7);
        check_cause("R7", 3'b101);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule